// File: doc/BRIEF.md
# Vector Memory Access Legality Checker

This block screens a unit-stride or strided vector load or store before it issues. From the access element width, the currently selected element width and the register-group multiplier, it works out how many vector registers each field of the access occupies. It then tests that group size against the register number, the number of segment fields and, for loads, the mask register.

All of the multiplier arithmetic uses powers of two, so the block needs no divider. A request is accepted when `req_valid` is high. One clock later, `rsp_valid` pulses and the block presents:
- the effective group size in registers,
- a legal flag,
- a cause code that names the first rule the request broke.

Address generation, memory traffic and the register file are outside this block.

Top module: `vmem_legal_chk`

## Requirements
- R1: Width codes on `eew_code` and `sew_code` are 0=8, 1=16, 2=32 and 3=64 bits. `lmul_exp` is a two's-complement base-2 exponent of the group multiplier, so 3'b101 means 1/8 and 3'b011 means 8.
- R2: The group exponent is eew_code − sew_code + lmul_exp. When that exponent is 0 or less, the group size `emul` is 1 register, so fractional groups round up. Otherwise `emul` is 2 raised to the exponent.
- R3: A group exponent above 3 (a group of more than 8 registers) gives cause 1 (range), and `emul` reads 0.
- R4: When `vreg` is not a multiple of `emul`, the cause is 2 (alignment).
- R5: The field count is `nf_enc`+1. The cause is 3 (group overflow) when field count × `emul` exceeds 8, or when `vreg` + field count × `emul` exceeds 32.
- R6: A load (`is_load`=1) with masking on (`vm`=0) and `vreg`=0 gives cause 4 (mask overlap). A store with the same fields is not subject to this rule.
- R7: When several rules fail, the reported cause is the lowest-numbered one, in the order range, alignment, group overflow, mask overlap. `legal` is 1 exactly when the cause is 0.
- R8: The result appears on the first rising edge after `req_valid` is sampled high. At that edge `rsp_valid` is 1 for that cycle. In cycles without a request, `rsp_valid` is 0 and `emul`, `legal` and `cause` keep their values.
- R9: After reset, `rsp_valid`, `legal`, `cause` and `emul` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| eew_code | input | 2 | Access element width code |
| sew_code | input | 2 | Selected element width code |
| lmul_exp | input | 3 | Signed exponent of the group multiplier |
| nf_enc | input | 3 | Encoded field count (count minus one) |
| vreg | input | 5 | Destination or store-data register |
| vm | input | 1 | 1 = unmasked, 0 = masked |
| is_load | input | 1 | 1 = load, 0 = store |
| rsp_valid | output | 1 | Result strobe |
| emul | output | 4 | Effective group size in registers (0 on range failure) |
| legal | output | 1 | Request is legal |
| cause | output | 3 | 0 ok, 1 range, 2 alignment, 3 group overflow, 4 mask overlap |

## Verification
The assertions rebuild each rule from the request fields sampled one cycle before `rsp_valid`. They therefore assume the inputs are steady around the sampling edge, and that `lmul_exp` stays within −3..+3. The bench changes inputs only on falling edges and uses only exponents in that range. Each directed case is built so that one rule, or a chosen pair of rules, fails. This exercises both the individual causes and the priority between them.

// File: rtl/vmem_legal_chk.sv
module vmem_legal_chk #(
  parameter int NUM_VREGS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] eew_code,
  input  logic [1:0] sew_code,
  input  logic [2:0] lmul_exp,
  input  logic [2:0] nf_enc,
  input  logic [4:0] vreg,
  input  logic       vm,
  input  logic       is_load,
  output logic       rsp_valid,
  output logic [3:0] emul,
  output logic       legal,
  output logic [2:0] cause
);
  localparam int MAX_GROUP = NUM_VREGS / 4;

  logic [4:0] grp_exp;
  logic       too_big, frac;
  logic [1:0] shamt;
  logic [3:0] emul_c, fields;
  logic [6:0] total;
  logic       align_bad, group_bad, mask_bad;
  logic [2:0] cause_c;

  assign grp_exp = {3'b000, eew_code} - {3'b000, sew_code} + {{2{lmul_exp[2]}}, lmul_exp};
  assign frac    = grp_exp[4] || (grp_exp == 5'd0);
  assign too_big = !grp_exp[4] && (grp_exp > 5'd3);
  assign shamt   = frac ? 2'd0 : grp_exp[1:0];
  assign emul_c  = too_big ? 4'd0 : (4'd1 << shamt);
  assign fields  = {1'b0, nf_enc} + 4'd1;
  assign total   = {3'b000, fields} << shamt;

  assign align_bad = ({1'b0, vreg[2:0]} & (emul_c - 4'd1)) != 4'd0;
  assign group_bad = (total > 7'(MAX_GROUP)) ||
                     (({2'b00, vreg} + total) > 7'(NUM_VREGS));
  assign mask_bad  = is_load && !vm && (vreg == 5'd0);

  always_comb begin
    if (too_big)        cause_c = 3'd1;
    else if (align_bad) cause_c = 3'd2;
    else if (group_bad) cause_c = 3'd3;
    else if (mask_bad)  cause_c = 3'd4;
    else                cause_c = 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      emul      <= '0;
      legal     <= 1'b0;
      cause     <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        emul  <= emul_c;
        legal <= (cause_c == 3'd0);
        cause <= cause_c;
      end
    end
  end
endmodule

module vmem_legal_chk_props (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] nf_enc,
  input logic [4:0] vreg,
  input logic       vm,
  input logic       is_load,
  input logic       rsp_valid,
  input logic [3:0] emul,
  input logic       legal,
  input logic [2:0] cause
);
  p_group_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && legal |-> ($onehot(emul) && emul <= 4'd8));

  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && legal |-> (({1'b0, $past(vreg[2:0])} & (emul - 4'd1)) == 4'd0));

  p_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && legal |->
      ((({4'b0, $past(nf_enc)} + 7'd1) * {3'b0, emul}) <= 7'd8) &&
      (({2'b0, $past(vreg)} + ({4'b0, $past(nf_enc)} + 7'd1) * {3'b0, emul}) <= 7'd32));

  p_no_mask_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && legal && $past(is_load) && !$past(vm) |-> $past(vreg) != 5'd0);

  p_legal_iff_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (legal == (cause == 3'd0)) && (cause <= 3'd4));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(emul) && $stable(legal) && $stable(cause));
endmodule

bind vmem_legal_chk vmem_legal_chk_props u_props (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .nf_enc(nf_enc),
  .vreg(vreg), .vm(vm), .is_load(is_load), .rsp_valid(rsp_valid),
  .emul(emul), .legal(legal), .cause(cause)
);

// File: tb/tb_vmem_legal_chk.sv
module tb_vmem_legal_chk;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] eew_code = '0, sew_code = '0;
  logic [2:0] lmul_exp = '0, nf_enc = '0;
  logic [4:0] vreg = '0;
  logic       vm = 1'b1, is_load = 1'b0;
  logic       rsp_valid, legal;
  logic [3:0] emul;
  logic [2:0] cause;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmem_legal_chk dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .eew_code(eew_code),
    .sew_code(sew_code), .lmul_exp(lmul_exp), .nf_enc(nf_enc), .vreg(vreg),
    .vm(vm), .is_load(is_load), .rsp_valid(rsp_valid), .emul(emul),
    .legal(legal), .cause(cause)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(string tag, int ew, int sw, int lm, int nf, int rg,
                     bit m, bit ld, int exp_emul, int exp_cause);
    @(negedge clk);
    eew_code = 2'(ew); sew_code = 2'(sw); lmul_exp = 3'(lm);
    nf_enc = 3'(nf); vreg = 5'(rg); vm = m; is_load = ld;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, rsp_valid, 1);
    check({tag, " emul"}, emul, exp_emul);
    check({tag, " cause"}, cause, exp_cause);
    check({tag, " legal"}, legal, exp_cause == 0);
  endtask

  task automatic test_reset();
    check("R9 valid", rsp_valid, 0);
    check("R9 emul", emul, 0);
    check("R9 legal", legal, 0);
    check("R9 cause", cause, 0);
  endtask

  task automatic test_groups();
    run("R1 R2 equal widths", 2, 2, 0, 0, 5, 1, 0, 1, 0);
    run("R2 widest group", 3, 0, 0, 0, 8, 1, 0, 8, 0);
    run("R2 fraction rounds up", 0, 3, -3, 0, 31, 1, 0, 1, 0);
    run("R1 R2 fractional lmul", 2, 1, -1, 0, 3, 1, 1, 1, 0);
    run("R3 range", 3, 0, 1, 0, 0, 1, 0, 0, 1);
  endtask

  task automatic test_rules();
    run("R4 misaligned", 1, 0, 1, 0, 6, 1, 0, 4, 2);
    run("R5 exact fit", 1, 0, 0, 3, 24, 1, 0, 2, 0);
    run("R5 past top", 1, 0, 0, 3, 26, 1, 0, 2, 3);
    run("R5 too many fields", 1, 0, 0, 4, 0, 1, 0, 2, 3);
    run("R6 masked load v0", 0, 0, 0, 0, 0, 0, 1, 1, 4);
    run("R6 masked store v0", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    run("R6 unmasked load v0", 0, 0, 0, 0, 0, 1, 1, 1, 0);
  endtask

  task automatic test_priority();
    run("R7 range over align", 3, 0, 1, 0, 3, 0, 1, 0, 1);
    run("R7 align over group", 1, 0, 1, 0, 30, 1, 0, 4, 2);
    run("R7 group over mask", 1, 0, 0, 4, 0, 0, 1, 2, 3);
  endtask

  task automatic test_hold();
    run("R8 setup", 1, 0, 1, 0, 6, 1, 0, 4, 2);
    @(negedge clk);
    vreg = 5'd0; eew_code = 2'd0;
    @(negedge clk);
    check("R8 idle valid", rsp_valid, 0);
    check("R8 idle emul", emul, 4);
    check("R8 idle cause", cause, 2);
    check("R8 idle legal", legal, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_groups();
    test_rules();
    test_priority();
    test_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule